// File: doc/BRIEF.md
# Cache Tag Directory with Saturating-Age Replacement

This block is a tag-only cache directory. It takes one byte address per cycle, decides whether the block holding that address is already present, and updates its tags in the same cycle. It stores no data. It answers only hit or miss, and it keeps running statistics. Parameters set the address width, block size, total capacity, associativity (1 or 4) and the counter width.

The directory can work as one unified store. It can also be built as two independent halves, one for instruction fetches and one for data accesses, with each half holding half of the capacity. A two-bit access-kind input chooses the half. In 4-way operation, a miss first fills the lowest-numbered empty way of the set. When the set is full, the miss evicts a way chosen by small per-way age counters. These counters are updated only when a way is filled.

Each accepted request produces a registered result one cycle later. The statistics outputs count accesses, hits and misses, with hits and misses separated by directory side.

Top module: `cache_tag_dir`

## Requirements
- R1: The address divides into three fields. The low log2(BLOCK_BYTES) bits are the byte offset and are ignored for lookup. The next log2(sets) bits select the set. The remaining upper bits form the tag. Two addresses in the same block therefore hit on each other.
- R2: With WAYS=1, an access hits only when the indexed line is valid and its tag matches. Any other access is a miss that stores the new tag and marks the line valid, replacing any previous tag.
- R3: With WAYS=4, an access hits when any valid way of the set holds a matching tag. A hit leaves every age counter unchanged.
- R4: On a 4-way miss in a set that has an empty way, the lowest-numbered empty way is filled and marked valid. Its age becomes 0. Each of the other ways in the set has its age raised by one, stopping at 3.
- R5: On a 4-way miss in a full set, the victim is the lowest-numbered way holding the largest age in the set. The victim takes the new tag and age 0, and the other ways age by one, saturating at 3.
- R6: With SPLIT=1, there are two independent directories, each holding half of the capacity. Access kind 2 uses the instruction directory. Kinds 0, 1 and 3 use the data directory.
- R7: Every accepted request increments the access count. Hits and misses are counted separately. With SPLIT=1 they are further divided into instruction and data counts. With SPLIT=0, every result is counted in the data counts and the instruction counts stay 0.
- R8: `req_ready` is high whenever reset is low. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `rsp_valid` pulses high for exactly one cycle after each accepted request, carrying `rsp_hit`. `rsp_hit` is 0 whenever `rsp_valid` is 0.
- R9: A synchronous active-high reset invalidates every line, clears every age and zeroes every counter. After reset, a previously present address misses.
- R10: Each counter stops at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Byte address |
| req_kind | input | 2 | Access kind; 2 = instruction fetch |
| rsp_valid | output | 1 | Result pulse, one cycle after acceptance |
| rsp_hit | output | 1 | Result is a hit |
| cnt_access | output | CNT_W | Accepted request count |
| cnt_d_hit | output | CNT_W | Data (or unified) hit count |
| cnt_d_miss | output | CNT_W | Data (or unified) miss count |
| cnt_i_hit | output | CNT_W | Instruction hit count |
| cnt_i_miss | output | CNT_W | Instruction miss count |

## Verification
The bench builds two instances side by side and feeds both the same request stream. The first is a 4-way split directory with 16-byte blocks and 256 bytes, so each side has only two sets; with so few sets, full-set evictions, saturated ages and side separation show up within a few dozen requests. The second is a direct-mapped unified directory of eight lines, where conflicting tags evict each other at once and all results land in the data counts. Both instances use 6-bit counters, so saturation at 63 is reached well inside the run.

// File: rtl/cache_dir_pkg.sv
package cache_dir_pkg;

    // access kinds carried on req_kind
    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_OTHER = 2'd3
    } acc_kind_e;

    localparam int        AGE_W   = 2;
    localparam logic [1:0] AGE_TOP = 2'd3;

    // statistics slots
    localparam int N_STAT   = 5;
    localparam int ST_ACC   = 0;
    localparam int ST_DHIT  = 1;
    localparam int ST_DMISS = 2;
    localparam int ST_IHIT  = 3;
    localparam int ST_IMISS = 4;

    typedef struct packed {
        logic hit;
        logic instr;
    } result_t;

    function automatic logic [AGE_W-1:0] age_bump(input logic [AGE_W-1:0] a);
        return (a == AGE_TOP) ? a : a + 1'b1;
    endfunction

endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    logic [OFF_W-1:0] unused_off;

    assign unused_off = addr[OFF_W-1:0];
    assign idx        = addr[OFF_W +: IDX_W];
    assign tag        = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/cache_sat_ctr.sv
module cache_sat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (inc && (q != {W{1'b1}}))
            q <= q + 1'b1;
    end
endmodule

// File: rtl/cache_tag_bank.sv
module cache_tag_bank
    import cache_dir_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int SETS  = 2,
    parameter int IDX_W = 1,
    parameter int TAG_W = 27
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    output logic             look_hit
);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  match;
    logic [WAY_W-1:0] vic;
    logic             fill;

    always_comb begin
        match = '0;
        for (int w = 0; w < WAYS; w++)
            match[w] = vld_q[idx][w] && (tag_q[idx][w] == tag);
    end

    assign look_hit = |match;
    assign fill     = upd_en && !look_hit;

    generate
        if (WAYS > 1) begin : g_assoc
            logic [AGE_W-1:0] age_q [SETS][WAYS];
            logic [AGE_W-1:0] top_age;
            logic [WAY_W-1:0] empty_way, old_way;
            logic             empty_found, old_found;

            always_comb begin
                empty_found = 1'b0;
                empty_way   = '0;
                for (int w = 0; w < WAYS; w++) begin
                    if (!vld_q[idx][w] && !empty_found) begin
                        empty_found = 1'b1;
                        empty_way   = WAY_W'(w);
                    end
                end
                top_age = '0;
                for (int w = 0; w < WAYS; w++)
                    if (age_q[idx][w] > top_age)
                        top_age = age_q[idx][w];
                old_found = 1'b0;
                old_way   = '0;
                for (int w = 0; w < WAYS; w++) begin
                    if (!old_found && (age_q[idx][w] == top_age)) begin
                        old_found = 1'b1;
                        old_way   = WAY_W'(w);
                    end
                end
            end

            assign vic = empty_found ? empty_way : old_way;

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int s = 0; s < SETS; s++)
                        for (int w = 0; w < WAYS; w++)
                            age_q[s][w] <= '0;
                end else if (fill) begin
                    for (int w = 0; w < WAYS; w++)
                        age_q[idx][w] <= (WAY_W'(w) == vic) ? '0 : age_bump(age_q[idx][w]);
                end
            end
        end else begin : g_direct
            assign vic = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                vld_q[s] <= '0;
        end else if (fill) begin
            vld_q[idx][vic] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill)
            tag_q[idx][vic] <= tag;
    end
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
    import cache_dir_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 16,
    parameter int CACHE_BYTES = 1024,
    parameter int WAYS        = 4,
    parameter int SPLIT       = 1,
    parameter int CNT_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [CNT_W-1:0]  cnt_access,
    output logic [CNT_W-1:0]  cnt_d_hit,
    output logic [CNT_W-1:0]  cnt_d_miss,
    output logic [CNT_W-1:0]  cnt_i_hit,
    output logic [CNT_W-1:0]  cnt_i_miss
);
    localparam int LINES     = CACHE_BYTES / BLOCK_BYTES;
    localparam int NDIR      = (SPLIT != 0) ? 2 : 1;
    localparam int DIR_LINES = LINES / NDIR;
    localparam int SETS      = DIR_LINES / WAYS;
    localparam int OFF_W     = $clog2(BLOCK_BYTES);
    localparam int IDX_W     = $clog2(SETS);
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W;

    logic             accept;
    logic             is_instr;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic [NDIR-1:0]  hit_vec;
    logic [NDIR-1:0]  upd_vec;
    result_t          res;
    logic [N_STAT-1:0] stat_inc;
    logic [CNT_W-1:0]  stat_q [N_STAT];

    assign req_ready = !rst;
    assign accept    = req_valid && req_ready;
    assign is_instr  = (SPLIT != 0) && (acc_kind_e'(req_kind) == KIND_FETCH);

    cache_addr_split #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_split (
        .addr(req_addr), .idx(idx), .tag(tag)
    );

    generate
        for (genvar d = 0; d < NDIR; d++) begin : g_dir
            localparam bit SIDE_I = (d == 1);
            assign upd_vec[d] = accept && (is_instr == SIDE_I);
            cache_tag_bank #(
                .WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)
            ) u_bank (
                .clk(clk), .rst(rst), .upd_en(upd_vec[d]),
                .idx(idx), .tag(tag), .look_hit(hit_vec[d])
            );
        end
    endgenerate

    assign res.instr = is_instr;
    assign res.hit   = (is_instr && (NDIR == 2)) ? hit_vec[NDIR-1] : hit_vec[0];

    always_comb begin
        stat_inc           = '0;
        stat_inc[ST_ACC]   = accept;
        stat_inc[ST_DHIT]  = accept && !res.instr &&  res.hit;
        stat_inc[ST_DMISS] = accept && !res.instr && !res.hit;
        stat_inc[ST_IHIT]  = accept &&  res.instr &&  res.hit;
        stat_inc[ST_IMISS] = accept &&  res.instr && !res.hit;
    end

    generate
        for (genvar g = 0; g < N_STAT; g++) begin : g_stat
            cache_sat_ctr #(.W(CNT_W)) u_ctr (
                .clk(clk), .rst(rst), .inc(stat_inc[g]), .q(stat_q[g])
            );
        end
    endgenerate

    assign cnt_access = stat_q[ST_ACC];
    assign cnt_d_hit  = stat_q[ST_DHIT];
    assign cnt_d_miss = stat_q[ST_DMISS];
    assign cnt_i_hit  = stat_q[ST_IHIT];
    assign cnt_i_miss = stat_q[ST_IMISS];

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
        end else begin
            rsp_valid <= accept;
            rsp_hit   <= accept && res.hit;
        end
    end
endmodule

// File: rtl/cache_tag_dir_chk.sv
module cache_tag_dir_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_kind,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [CNT_W-1:0]  cnt_access,
    input logic [CNT_W-1:0]  cnt_d_hit,
    input logic [CNT_W-1:0]  cnt_d_miss,
    input logic [CNT_W-1:0]  cnt_i_hit,
    input logic [CNT_W-1:0]  cnt_i_miss
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic              acc;
    logic [CNT_W+2:0]  part_sum;

    assign acc      = req_valid && req_ready;
    assign part_sum = (CNT_W+3)'(cnt_d_hit) + (CNT_W+3)'(cnt_d_miss)
                    + (CNT_W+3)'(cnt_i_hit) + (CNT_W+3)'(cnt_i_miss);

    p_rsp_follows_r8: assert property (@(posedge clk) disable iff (rst)
        acc |=> rsp_valid);

    p_no_stray_rsp_r8: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !rsp_valid);

    p_hit_qualified_r8: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !rsp_hit);

    // R2 / R3: an address just filled must hit when asked again at once
    p_repeat_hits_r3: assert property (@(posedge clk) disable iff (rst)
        (acc && $past(acc) && (req_addr == $past(req_addr)) && (req_kind == $past(req_kind)))
        |=> rsp_hit);

    p_access_step_r7: assert property (@(posedge clk) disable iff (rst)
        (acc && (cnt_access != TOP)) |=> (cnt_access == $past(cnt_access) + 1'b1));

    p_sum_matches_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt_access != TOP) |-> (part_sum == (CNT_W+3)'(cnt_access)));

    p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (cnt_access == TOP) |=> (cnt_access == TOP));
endmodule

bind cache_tag_dir cache_tag_dir_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .cnt_access(cnt_access), .cnt_d_hit(cnt_d_hit),
    .cnt_d_miss(cnt_d_miss), .cnt_i_hit(cnt_i_hit), .cnt_i_miss(cnt_i_miss)
);

// File: tb/cache_tag_dir_tb.sv
`timescale 1ns/1ps
module cache_tag_dir_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;

    logic       a_rdy, a_rv, a_rh;
    logic [5:0] a_acc, a_dh, a_dm, a_ih, a_im;
    logic       b_rdy, b_rv, b_rh;
    logic [5:0] b_acc, b_dh, b_dm, b_ih, b_im;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cache_tag_dir #(.ADDR_W(32), .BLOCK_BYTES(16), .CACHE_BYTES(256),
                    .WAYS(4), .SPLIT(1), .CNT_W(6)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(a_rdy),
        .req_addr(req_addr), .req_kind(req_kind), .rsp_valid(a_rv), .rsp_hit(a_rh),
        .cnt_access(a_acc), .cnt_d_hit(a_dh), .cnt_d_miss(a_dm),
        .cnt_i_hit(a_ih), .cnt_i_miss(a_im));

    cache_tag_dir #(.ADDR_W(32), .BLOCK_BYTES(16), .CACHE_BYTES(128),
                    .WAYS(1), .SPLIT(0), .CNT_W(6)) dut_dm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(b_rdy),
        .req_addr(req_addr), .req_kind(req_kind), .rsp_valid(b_rv), .rsp_hit(b_rh),
        .cnt_access(b_acc), .cnt_d_hit(b_dh), .cnt_d_miss(b_dm),
        .cnt_i_hit(b_ih), .cnt_i_miss(b_im));

    // behavioural reference: config 0 = 4-way split, config 1 = direct unified
    int c_ways [2] = '{4, 1};
    int c_sets [2] = '{2, 8};
    int c_off  [2] = '{4, 4};
    int c_idxw [2] = '{1, 3};
    int c_split[2] = '{1, 0};

    int unsigned m_tag [2][2][8][4];
    bit          m_vld [2][2][8][4];
    int          m_age [2][2][8][4];
    int          m_cnt [2][5];
    bit          e_hit [2];
    bit          e_rv;
    string       e_tag;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < 2; c++) begin
            for (int s = 0; s < 2; s++)
                for (int i = 0; i < 8; i++)
                    for (int w = 0; w < 4; w++) begin
                        m_vld[c][s][i][w] = 1'b0;
                        m_age[c][s][i][w] = 0;
                        m_tag[c][s][i][w] = 0;
                    end
            for (int k = 0; k < 5; k++) m_cnt[c][k] = 0;
            e_hit[c] = 1'b0;
        end
        e_rv = 1'b0;
    endtask

    task automatic bump(input int c, input int k);
        if (m_cnt[c][k] < 63) m_cnt[c][k]++;
    endtask

    task automatic ref_access(input int c, input int unsigned a, input int kd);
        int side, idx, v, mx;
        int unsigned tg;
        bit hit;
        side = (c_split[c] != 0 && kd == 2) ? 1 : 0;
        idx  = (a >> c_off[c]) % c_sets[c];
        tg   = a >> (c_off[c] + c_idxw[c]);
        hit  = 1'b0;
        for (int w = 0; w < c_ways[c]; w++)
            if (m_vld[c][side][idx][w] && m_tag[c][side][idx][w] == tg) hit = 1'b1;
        if (!hit) begin
            v = -1;
            for (int w = 0; w < c_ways[c]; w++)
                if (!m_vld[c][side][idx][w] && v < 0) v = w;
            if (v < 0) begin
                mx = 0;
                for (int w = 0; w < c_ways[c]; w++)
                    if (m_age[c][side][idx][w] > mx) mx = m_age[c][side][idx][w];
                for (int w = 0; w < c_ways[c]; w++)
                    if (v < 0 && m_age[c][side][idx][w] == mx) v = w;
            end
            m_tag[c][side][idx][v] = tg;
            m_vld[c][side][idx][v] = 1'b1;
            for (int w = 0; w < c_ways[c]; w++) begin
                if (w == v) m_age[c][side][idx][w] = 0;
                else if (m_age[c][side][idx][w] < 3) m_age[c][side][idx][w]++;
            end
        end
        e_hit[c] = hit;
        bump(c, 0);
        if (side == 1) bump(c, hit ? 3 : 4);
        else           bump(c, hit ? 1 : 2);
    endtask

    task automatic cmp_one(input int c, input bit rdy, input bit rv, input bit rh,
                           input int acc, input int dh, input int dm, input int ih, input int im);
        string ct;
        ct = (m_cnt[c][0] == 63) ? "R10" : "R7";
        check(rdy == 1'b1, "R8", rdy, 1);
        check(rv == e_rv, "R8", rv, e_rv);
        if (e_rv) check(rh == e_hit[c], e_tag, rh, e_hit[c]);
        else      check(rh == 1'b0, "R8", rh, 0);
        check(acc == m_cnt[c][0], ct, acc, m_cnt[c][0]);
        check(dh  == m_cnt[c][1], ct, dh,  m_cnt[c][1]);
        check(dm  == m_cnt[c][2], ct, dm,  m_cnt[c][2]);
        check(ih  == m_cnt[c][3], ct, ih,  m_cnt[c][3]);
        check(im  == m_cnt[c][4], ct, im,  m_cnt[c][4]);
    endtask

    task automatic step(input bit v, input int unsigned a, input int kd, input string tg);
        @(negedge clk);
        cmp_one(0, a_rdy, a_rv, a_rh, a_acc, a_dh, a_dm, a_ih, a_im);
        cmp_one(1, b_rdy, b_rv, b_rh, b_acc, b_dh, b_dm, b_ih, b_im);
        req_valid = v;
        req_addr  = a;
        req_kind  = 2'(kd);
        e_rv      = v;
        e_tag     = tg;
        if (v) begin
            ref_access(0, a, kd);
            ref_access(1, a, kd);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(a_rdy == 1'b0 && b_rdy == 1'b0, "R8", a_rdy, 0);
        model_clear();
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        model_clear();
        do_reset();
        @(negedge clk);
        // R9: reset state at the ports
        check(a_rv == 1'b0 && b_rv == 1'b0, "R9", a_rv, 0);
        check(a_acc == 0 && b_acc == 0 && a_dm == 0 && b_dm == 0, "R9", a_acc, 0);

        // R1: same block, different offset
        step(1, 32'h0000_0100, 0, "R1");
        step(1, 32'h0000_010C, 0, "R1");
        step(0, 0, 0, "R8");
        // R4: fill empty ways of data set 0 in order
        step(1, 32'h0000_1000, 0, "R4");
        step(1, 32'h0000_2000, 1, "R4");
        step(1, 32'h0000_3000, 0, "R4");
        step(1, 32'h0000_4000, 3, "R4");
        // R3: hits leave ages alone
        step(1, 32'h0000_2004, 0, "R3");
        step(1, 32'h0000_4008, 0, "R3");
        step(1, 32'h0000_100F, 1, "R3");
        // R5: full set evictions
        step(1, 32'h0000_5000, 0, "R5");
        step(1, 32'h0000_1000, 0, "R5");
        step(1, 32'h0000_3000, 0, "R5");
        step(1, 32'h0000_2000, 0, "R5");
        step(1, 32'h0000_6000, 0, "R5");
        step(0, 0, 0, "R8");
        // R6: instruction side is separate
        step(1, 32'h0000_3000, 2, "R6");
        step(1, 32'h0000_3000, 2, "R6");
        step(1, 32'h0000_7000, 2, "R6");
        step(1, 32'h0000_7000, 0, "R6");
        // R2: direct-mapped conflicts plus mixed traffic
        step(1, 32'h0000_0080, 0, "R2");
        step(1, 32'h0000_0480, 0, "R2");
        step(1, 32'h0000_0080, 0, "R2");
        r = 32'hACE1;
        for (int n = 0; n < 140; n++) begin
            r = (r >> 1) ^ ((r & 1) ? 32'h0000_B400 : 0);
            step(((r >> 13) & 3) != 0,
                 (((r % 6) + 1) << 9) | (((r >> 3) & 7) << 4) | ((r >> 7) & 15),
                 (r >> 10) & 3, "R2");
        end
        step(0, 0, 0, "R8");
        @(negedge clk);
        check(a_acc == 63, "R10", a_acc, 63);
        check(b_acc == 63, "R10", b_acc, 63);

        // R9: reset forgets contents
        do_reset();
        step(1, 32'h0000_0100, 0, "R9");
        step(1, 32'h0000_0100, 0, "R9");
        step(0, 0, 0, "R9");
        step(0, 0, 0, "R9");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule